// File: doc/BRIEF.md
# Registered 12-to-24-bit Bus Exchanger

This block joins one narrow A port to a wide B side made of two halves, the low half and the high half. Together the two halves form a word twice the width of A. Going from A to B, each half has its own capture register and its own active-low capture enable. Two A words that arrive one after the other can therefore be placed side by side and shown as one wide word. Going from B to A, a select input picks one half, and that half passes through a single shared register before it reaches A.

Every control input is registered on the rising clock edge: the half select, both capture enables and the three active-low output enables. A control value sampled at one edge acts on data only at the next edge. Each port has a data bus and its own drive-enable output. The drive-enable stands in for the tri-state driver of that port and is high when the port should drive.

Top module: `bus_exchanger`

## Requirements
- R1: A synchronous active-high reset clears aOut, b1Out and b2Out to 0 and sets all three drive-enable outputs to 0. The registered controls reset to their inactive values: capture enables 1, output enables 1, select 0.
- R2: At a rising edge, b1Out loads aIn when capEn1N was 0 at the previous edge. Otherwise b1Out holds its value.
- R3: At a rising edge, b2Out loads aIn when capEn2N was 0 at the previous edge. Otherwise it holds. The two capture enables act independently of each other.
- R4: When the low half is enabled first and the high half next, two consecutive A words appear together as {b2Out, b1Out}.
- R5: aOut loads at every rising edge. It takes b1In when selIn was 0 at the previous edge and b2In when selIn was 1.
- R6: After each edge, aDriveEn, b1DriveEn and b2DriveEn equal the inverse of oeAN, oeB1N and oeB2N as sampled at that edge.
- R7: A control change sampled at an edge does not affect data loaded at that same edge. Its effect on data begins one edge later.
- R8: The data outputs show the register contents whatever the drive-enable state. Only the drive-enable outputs reflect the output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | 12 | A bus value, captured into the B halves |
| b1In | input | 12 | Low B half bus value for the return path |
| b2In | input | 12 | High B half bus value for the return path |
| selIn | input | 1 | Return half select: 0 low, 1 high |
| capEn1N | input | 1 | Low-half capture enable, active low |
| capEn2N | input | 1 | High-half capture enable, active low |
| oeAN | input | 1 | A port output enable, active low |
| oeB1N | input | 1 | Low B half output enable, active low |
| oeB2N | input | 1 | High B half output enable, active low |
| aOut | output | 12 | Registered return data toward A |
| aDriveEn | output | 1 | A port drives when high |
| b1Out | output | 12 | Low-half capture register |
| b1DriveEn | output | 1 | Low B half drives when high |
| b2Out | output | 12 | High-half capture register |
| b2DriveEn | output | 1 | High B half drives when high |

## Verification
The assertions assume that every control input is a defined 0 or 1 at each rising edge. They also assume that reset has been low for at least one edge, so the control registers hold sampled inputs and not reset values. The bench respects this by changing every input only on the falling edge. Its sweep covers all 64 combinations of the six control bits, with data words computed from the step index, so each load, hold and select case is seen after a full control latency.

// File: rtl/bx_pkg.sv
package bx_pkg;
  // Strobes sent from the control stage to the datapath
  typedef struct packed {
    logic load1;   // capture A into the low half
    logic load2;   // capture A into the high half
    logic pickHi;  // return path takes the high half
    logic driveA;
    logic driveB1;
    logic driveB2;
  } strobe_t;

  localparam int NUM_CTRL = 6;
endpackage

// File: rtl/bx_ctrl.sv
module bx_ctrl
  import bx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    selIn,
  input  logic    capEn1N,
  input  logic    capEn2N,
  input  logic    oeAN,
  input  logic    oeB1N,
  input  logic    oeB2N,
  output strobe_t strobes
);
  // Bit layout: [0] sel, [1] cap1N, [2] cap2N, [3] oeAN, [4] oeB1N, [5] oeB2N
  localparam logic [NUM_CTRL-1:0] CTRL_RESET = 6'b111110;

  logic [NUM_CTRL-1:0] ctrlIn;
  logic [NUM_CTRL-1:0] ctrlQ;

  assign ctrlIn = {oeB2N, oeB1N, oeAN, capEn2N, capEn1N, selIn};

  // One register stage per control bit, each with its own reset value
  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrlReg
    always_ff @(posedge clk) begin
      if (rst) ctrlQ[i] <= CTRL_RESET[i];
      else     ctrlQ[i] <= ctrlIn[i];
    end
  end

  always_comb begin
    strobes.pickHi  = ctrlQ[0];
    strobes.load1   = ~ctrlQ[1];
    strobes.load2   = ~ctrlQ[2];
    strobes.driveA  = ~ctrlQ[3];
    strobes.driveB1 = ~ctrlQ[4];
    strobes.driveB2 = ~ctrlQ[5];
  end
endmodule

// File: rtl/bx_datapath.sv
module bx_datapath
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  strobe_t      strobes,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  output logic [W-1:0] aOut,
  output logic         aDriveEn,
  output logic [W-1:0] b1Out,
  output logic         b1DriveEn,
  output logic [W-1:0] b2Out,
  output logic         b2DriveEn
);
  localparam int HALVES = 2;

  logic [HALVES-1:0]  loadVec;
  logic [W-1:0]       halfReg [HALVES];
  logic [W-1:0]       retMux;
  logic [W-1:0]       retReg;

  assign loadVec = {strobes.load2, strobes.load1};

  // Wide-side capture registers, one per half
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst)             halfReg[h] <= '0;
      else if (loadVec[h]) halfReg[h] <= aIn;
    end
  end

  // Shared return register behind the half-select mux
  assign retMux = strobes.pickHi ? b2In : b1In;

  always_ff @(posedge clk) begin
    if (rst) retReg <= '0;
    else     retReg <= retMux;
  end

  assign aOut      = retReg;
  assign b1Out     = halfReg[0];
  assign b2Out     = halfReg[1];
  assign aDriveEn  = strobes.driveA;
  assign b1DriveEn = strobes.driveB1;
  assign b2DriveEn = strobes.driveB2;
endmodule

// File: rtl/bus_exchanger.sv
module bus_exchanger
  import bx_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] b1In,
  input  logic [W-1:0] b2In,
  input  logic         selIn,
  input  logic         capEn1N,
  input  logic         capEn2N,
  input  logic         oeAN,
  input  logic         oeB1N,
  input  logic         oeB2N,
  output logic [W-1:0] aOut,
  output logic         aDriveEn,
  output logic [W-1:0] b1Out,
  output logic         b1DriveEn,
  output logic [W-1:0] b2Out,
  output logic         b2DriveEn
);
  strobe_t strobes;

  bx_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .selIn   (selIn),
    .capEn1N (capEn1N),
    .capEn2N (capEn2N),
    .oeAN    (oeAN),
    .oeB1N   (oeB1N),
    .oeB2N   (oeB2N),
    .strobes (strobes)
  );

  bx_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .aIn       (aIn),
    .b1In      (b1In),
    .b2In      (b2In),
    .aOut      (aOut),
    .aDriveEn  (aDriveEn),
    .b1Out     (b1Out),
    .b1DriveEn (b1DriveEn),
    .b2Out     (b2Out),
    .b2DriveEn (b2DriveEn)
  );
endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] aIn,
  input logic [W-1:0] b1In,
  input logic [W-1:0] b2In,
  input logic         selIn,
  input logic         capEn1N,
  input logic         capEn2N,
  input logic         oeAN,
  input logic         oeB1N,
  input logic         oeB2N,
  input logic [W-1:0] aOut,
  input logic         aDriveEn,
  input logic [W-1:0] b1Out,
  input logic         b1DriveEn,
  input logic [W-1:0] b2Out,
  input logic         b2DriveEn
);
  // High when reset was low at the previous edge
  logic pastOk = 1'b0;
  always_ff @(posedge clk) pastOk <= !rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!aDriveEn && !b1DriveEn && !b2DriveEn && aOut == '0 && b1Out == '0 && b2Out == '0));

  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !$past(capEn1N)) |=> (b1Out == $past(aIn)));

  // R2
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(capEn1N)) |=> $stable(b1Out));

  // R3
  high_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !$past(capEn2N)) |=> (b2Out == $past(aIn)));

  // R3
  high_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(capEn2N)) |=> $stable(b2Out));

  // R5
  ret_low_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && !$past(selIn)) |=> (aOut == $past(b1In)));

  // R5
  ret_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pastOk && $past(selIn)) |=> (aOut == $past(b2In)));

  // R6
  drive_map_chk: assert property (@(posedge clk) disable iff (rst)
    pastOk |-> (aDriveEn == !$past(oeAN) && b1DriveEn == !$past(oeB1N) && b2DriveEn == !$past(oeB2N)));
endmodule

bind bus_exchanger bx_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .aIn(aIn), .b1In(b1In), .b2In(b2In),
  .selIn(selIn), .capEn1N(capEn1N), .capEn2N(capEn2N),
  .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N),
  .aOut(aOut), .aDriveEn(aDriveEn), .b1Out(b1Out), .b1DriveEn(b1DriveEn),
  .b2Out(b2Out), .b2DriveEn(b2DriveEn)
);

// File: tb/sim_bus_exchanger.sv
`timescale 1ns/1ps
module sim_bus_exchanger;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic selIn = 1'b0, capEn1N = 1'b1, capEn2N = 1'b1;
  logic oeAN = 1'b1, oeB1N = 1'b1, oeB2N = 1'b1;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aDriveEn, b1DriveEn, b2DriveEn;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_exchanger #(.W(W)) u0 (
    .clk(clk), .rst(rst), .aIn(aIn), .b1In(b1In), .b2In(b2In),
    .selIn(selIn), .capEn1N(capEn1N), .capEn2N(capEn2N),
    .oeAN(oeAN), .oeB1N(oeB1N), .oeB2N(oeB2N),
    .aOut(aOut), .aDriveEn(aDriveEn), .b1Out(b1Out), .b1DriveEn(b1DriveEn),
    .b2Out(b2Out), .b2DriveEn(b2DriveEn)
  );

  // Reference state: registered controls and data registers
  logic mSel = 1'b0, mCe1 = 1'b1, mCe2 = 1'b1, mOeA = 1'b1, mOe1 = 1'b1, mOe2 = 1'b1;
  logic [W-1:0] mA = '0, mB1 = '0, mB2 = '0;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive inputs at the falling edge, advance one rising edge, update the model
  task automatic step(input logic r, input logic [5:0] c, input logic [W-1:0] a,
                      input logic [W-1:0] x1, input logic [W-1:0] x2);
    @(negedge clk);
    rst = r; aIn = a; b1In = x1; b2In = x2;
    {oeB2N, oeB1N, oeAN, capEn2N, capEn1N, selIn} = c;
    @(posedge clk);
    if (r) begin
      mA = '0; mB1 = '0; mB2 = '0;
      mSel = 1'b0; mCe1 = 1'b1; mCe2 = 1'b1; mOeA = 1'b1; mOe1 = 1'b1; mOe2 = 1'b1;
    end else begin
      if (!mCe1) mB1 = a;
      if (!mCe2) mB2 = a;
      mA = mSel ? x2 : x1;
      {mOe2, mOe1, mOeA, mCe2, mCe1, mSel} = c;
    end
    #1;
  endtask

  task automatic compareAll();
    check("R2 b1Out", b1Out, mB1);
    check("R3 b2Out", b2Out, mB2);
    check("R5 aOut", aOut, mA);
    check("R6 drives", {9'd0, aDriveEn, b1DriveEn, b2DriveEn}, {9'd0, !mOeA, !mOe1, !mOe2});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state
    step(1'b1, 6'b111111, 12'hABC, 12'h123, 12'h456);
    step(1'b1, 6'b000000, 12'hABC, 12'h123, 12'h456);
    check("R1 aOut", aOut, '0);
    check("R1 b1Out", b1Out, '0);
    check("R1 b2Out", b2Out, '0);
    check("R1 drives", {9'd0, aDriveEn, b1DriveEn, b2DriveEn}, '0);

    // R7: enable requested at this edge must not load at this edge
    step(1'b0, 6'b111110, 12'h111, 12'h0, 12'h0);
    step(1'b0, 6'b111100, 12'h5A5, 12'h0, 12'h0);
    check("R7 no same-edge load", b1Out, 12'h000);
    step(1'b0, 6'b111110, 12'h3C3, 12'h0, 12'h0);
    check("R7 load one edge later", b1Out, 12'h3C3);

    // R4 and R8: two words assembled with all output enables inactive
    step(1'b0, 6'b111100, 12'hFFF, 12'h0, 12'h0);
    step(1'b0, 6'b111010, 12'h2A1, 12'h0, 12'h0);
    step(1'b0, 6'b111110, 12'h7E4, 12'h0, 12'h0);
    step(1'b0, 6'b111110, 12'h000, 12'h0, 12'h0);
    check("R4 wide word hi", b2Out, 12'h7E4);
    check("R4 wide word lo", b1Out, 12'h2A1);
    check("R8 data visible while not driving", {11'd0, b1DriveEn | b2DriveEn}, 12'h000);

    // Sweep all control combinations with computed data words
    for (int i = 0; i < 256; i++) begin
      step(1'b0, i[5:0] ^ i[7:2], W'((i * 37 + 5) % 4096), W'((i * 91 + 17) % 4096),
           W'((i * 53 + 1234) % 4096));
      compareAll();
    end

    // R1: reset again mid-run
    step(1'b1, 6'b000000, 12'h999, 12'h888, 12'h777);
    compareAll();
    check("R1 reset mid-run", b2Out, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule